// File: doc/BRIEF.md
# Interrupt Acknowledge Daisy Chain

This block is a chain of acknowledge links, one per I/O port, with a shared identification bus. Each port raises a request with a one-cycle event pulse. The request is held in a pending flag, and software can read that flag at any time to find requesting ports by polling. When the processor raises its acknowledge line, the signal passes down the chain from link 0 (nearest the processor) toward the last link. Every link that is not requesting passes the acknowledge on to the next link. The first requesting link stops the acknowledge and places its own identification number on the shared bus. The processor reads that number to select a handler.

Position in the chain sets priority. Whether a link is requesting is decided on the cycle the acknowledge rises, and that decision holds until the acknowledge falls. A request that arrives in the middle of an acknowledge therefore cannot cut the chain or change the number on the bus. When the acknowledge falls, the link that took it clears its own pending flag. Software can also clear any pending flag directly. Each link's number is the parameter `ID_BASE` plus its position. The links drive an OR-combined bus, and each link contributes zero while it is not taking the acknowledge.

Top module: `iack_chain`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pending`, `id_bus` and `id_valid` are all zero.
- R2: A high `req_set[i]` at a clock edge makes `pending[i]` read 1 after that edge.
- R3: A high `sw_clr[i]` at a clock edge clears `pending[i]`. If `req_set[i]` is high at the same edge, the set wins and `pending[i]` reads 1.
- R4: While no link holds the acknowledge, `chain_ack_out` equals `cpu_ack` in the same cycle, with no register in the path.
- R5: When `cpu_ack` rises, the lowest-index link with `pending` set takes the acknowledge. `chain_ack_out` then stays low for as long as `cpu_ack` is high.
- R6: From the first clock edge after `cpu_ack` rises, and while it stays high, `id_valid` is 1 and `id_bus` equals `ID_BASE + k`, where k is the index of the link holding the acknowledge. With no holder, both are 0.
- R7: A request that arrives while `cpu_ack` is high sets `pending`. It does not change which link holds the acknowledge, `chain_ack_out`, or `id_bus` until `cpu_ack` falls.
- R8: At the first clock edge after `cpu_ack` falls, the link that held the acknowledge clears its `pending` bit. Other pending bits are unchanged. `id_valid` reads 0 after that edge.
- R9: At most one link holds the acknowledge at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ack | input | 1 | Acknowledge from the processor into link 0 |
| req_set | input | N_NODES | Per-port request event pulse |
| sw_clr | input | N_NODES | Per-port software clear of the pending flag |
| chain_ack_out | output | 1 | Acknowledge leaving the last link |
| pending | output | N_NODES | Pending flags, readable for polling |
| id_bus | output | ID_W | Registered identification number of the holder |
| id_valid | output | 1 | Registered: some link holds the acknowledge |

## Verification
On every cycle, the assertions check four things: the reset values, that at most one link holds the acknowledge, that a blocked chain never lets the acknowledge out, and that an idle bus reads zero. They also check that set pulses land in `pending` and that a completed acknowledge removes a pending bit.

Some behaviour only the bench's scenarios can show:
- that priority follows chain position;
- that the exact number `ID_BASE + k` appears one edge after the rise;
- that a mid-acknowledge request leaves the holder unchanged;
- that only the holder's flag clears when the acknowledge falls.

// File: rtl/iack_pkg.sv
package iack_pkg;
  function automatic logic [31:0] link_id(input logic [31:0] base, input int idx);
    return base + 32'(idx);
  endfunction
endpackage

// File: rtl/ack_link_node.sv
module ack_link_node #(
  parameter int          ID_W    = 8,
  parameter logic [ID_W-1:0] NODE_ID = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_set,
  input  logic            sw_clr,
  input  logic            ack_in,
  output logic            ack_out,
  output logic [ID_W-1:0] id_drive,
  output logic            pending,
  output logic            holding
);
  logic pend_q, seen_q, hold_q, hold_now, done;

  // The decision is taken on the rising cycle, then frozen until ack falls.
  always_comb begin
    hold_now = ack_in & (seen_q ? hold_q : pend_q);
    ack_out  = ack_in & ~hold_now;
    id_drive = hold_now ? NODE_ID : '0;
    done     = seen_q & ~ack_in & hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      seen_q <= ack_in;
      hold_q <= hold_now;
      if (req_set)             pend_q <= 1'b1;
      else if (sw_clr || done) pend_q <= 1'b0;
    end
  end

  assign pending = pend_q;
  assign holding = hold_now;
endmodule

// File: rtl/id_bus_merge.sv
module id_bus_merge #(
  parameter int LANES = 4,
  parameter int W     = 8
) (
  input  logic [LANES*W-1:0] lanes,
  output logic [W-1:0]       merged
);
  always_comb begin
    merged = '0;
    for (int i = 0; i < LANES; i++) merged |= lanes[i*W +: W];
  end
endmodule

// File: rtl/iack_chain.sv
module iack_chain #(
  parameter int              N_NODES = 4,
  parameter int              ID_W    = 8,
  parameter logic [ID_W-1:0] ID_BASE = 8'h20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_ack,
  input  logic [N_NODES-1:0] req_set,
  input  logic [N_NODES-1:0] sw_clr,
  output logic               chain_ack_out,
  output logic [N_NODES-1:0] pending,
  output logic [ID_W-1:0]    id_bus,
  output logic               id_valid
);
  localparam int BUS_BITS = N_NODES * ID_W;

  logic [N_NODES:0]    ack_link;
  logic [BUS_BITS-1:0] lanes;
  logic [N_NODES-1:0]  claim_vec;
  logic [ID_W-1:0]     merged;
  logic [ID_W-1:0]     id_q;
  logic                valid_q;

  assign ack_link[0] = cpu_ack;

  for (genvar g = 0; g < N_NODES; g++) begin : g_link
    localparam logic [ID_W-1:0] THIS_ID = ID_W'(iack_pkg::link_id(32'(ID_BASE), g));
    ack_link_node #(.ID_W(ID_W), .NODE_ID(THIS_ID)) node_i (
      .clk      (clk),
      .rst      (rst),
      .req_set  (req_set[g]),
      .sw_clr   (sw_clr[g]),
      .ack_in   (ack_link[g]),
      .ack_out  (ack_link[g+1]),
      .id_drive (lanes[g*ID_W +: ID_W]),
      .pending  (pending[g]),
      .holding  (claim_vec[g])
    );
  end

  id_bus_merge #(.LANES(N_NODES), .W(ID_W)) merge_i (
    .lanes  (lanes),
    .merged (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      id_q    <= merged;
      valid_q <= |claim_vec;
    end
  end

  assign chain_ack_out = ack_link[N_NODES];
  assign id_bus        = id_q;
  assign id_valid      = valid_q;
endmodule

// File: rtl/iack_chain_chk.sv
module iack_chain_chk #(
  parameter int N_NODES = 4,
  parameter int ID_W    = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_ack,
  input logic               chain_ack_out,
  input logic [N_NODES-1:0] req_set,
  input logic [N_NODES-1:0] pending,
  input logic [N_NODES-1:0] claim_vec,
  input logic [ID_W-1:0]    id_bus,
  input logic               id_valid
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pending == '0 && id_bus == '0 && !id_valid));

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (req_set != '0) |=> ((pending & $past(req_set)) == $past(req_set)));

  // R9
  single_holder_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(claim_vec));

  // R5
  blocked_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (claim_vec != '0) |-> !chain_ack_out);

  // R4
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    chain_ack_out |-> cpu_ack);

  // R6
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> (id_bus == '0));

  // R8
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cpu_ack) && $past(claim_vec) != '0 && req_set == '0)
      |=> ($countones(pending) < $past($countones(pending))));
endmodule

bind iack_chain iack_chain_chk #(.N_NODES(N_NODES), .ID_W(ID_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .cpu_ack       (cpu_ack),
  .chain_ack_out (chain_ack_out),
  .req_set       (req_set),
  .pending       (pending),
  .claim_vec     (claim_vec),
  .id_bus        (id_bus),
  .id_valid      (id_valid)
);

// File: tb/iack_chain_tb_top.sv
`timescale 1ns/1ps
module iack_chain_tb_top;
  localparam int N = 4;
  localparam int W = 8;
  localparam logic [W-1:0] BASE = 8'h20;

  logic clk = 0;
  logic rst = 1;
  logic cpu_ack = 0;
  logic [N-1:0] req_set = '0;
  logic [N-1:0] sw_clr = '0;
  logic chain_ack_out;
  logic [N-1:0] pending;
  logic [W-1:0] id_bus;
  logic id_valid;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  iack_chain #(.N_NODES(N), .ID_W(W), .ID_BASE(BASE)) dut_i (
    .clk(clk), .rst(rst), .cpu_ack(cpu_ack), .req_set(req_set), .sw_clr(sw_clr),
    .chain_ack_out(chain_ack_out), .pending(pending), .id_bus(id_bus), .id_valid(id_valid)
  );

  // {req_set, sw_clr, expected pending}
  localparam int NV = 7;
  localparam logic [3*N-1:0] VEC [NV] = '{
    {4'b0001, 4'b0000, 4'b0001},
    {4'b0100, 4'b0000, 4'b0101},
    {4'b0000, 4'b0001, 4'b0100},
    {4'b1000, 4'b1000, 4'b1100},
    {4'b0000, 4'b1100, 4'b0000},
    {4'b1010, 4'b0000, 4'b1010},
    {4'b0000, 4'b1010, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    at_neg(); req_set = m;
    after_edge(); req_set = '0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) after_edge();
    check("R1 pending", 32'(pending), 0);
    check("R1 id_bus", 32'(id_bus), 0);
    check("R1 id_valid", 32'(id_valid), 0);
    at_neg(); rst = 0;
    after_edge();
    check("R1 after release", 32'({pending, id_valid}), 0);

    // R2 R3 vector walk
    for (int v = 0; v < NV; v++) begin
      at_neg();
      req_set = VEC[v][3*N-1 -: N];
      sw_clr  = VEC[v][2*N-1 -: N];
      after_edge();
      req_set = '0; sw_clr = '0;
      check(v == 3 ? "R3 set beats clear" : "R2/R3 pending", 32'(pending), 32'(VEC[v][N-1:0]));
    end

    // R4 pass-through with nobody pending
    at_neg(); cpu_ack = 1; #1;
    check("R4 ack passes", 32'(chain_ack_out), 1);
    after_edge();
    check("R6 no holder valid", 32'(id_valid), 0);
    check("R6 no holder bus", 32'(id_bus), 0);
    at_neg(); cpu_ack = 0; #1;
    check("R4 ack drops", 32'(chain_ack_out), 0);
    after_edge();

    // R5 R6 R8 priority by position
    pulse_req(4'b0110);
    check("R2 two pending", 32'(pending), 32'b0110);
    at_neg(); cpu_ack = 1; #1;
    check("R5 blocked", 32'(chain_ack_out), 0);
    after_edge();
    check("R6 id of link1", 32'(id_bus), 32'(BASE + 1));
    check("R6 valid", 32'(id_valid), 1);
    repeat (3) after_edge();
    check("R6 held id", 32'(id_bus), 32'(BASE + 1));
    check("R5 still blocked", 32'(chain_ack_out), 0);
    at_neg(); cpu_ack = 0;
    after_edge();
    check("R8 holder cleared", 32'(pending), 32'b0100);
    check("R8 valid drops", 32'(id_valid), 0);
    at_neg(); cpu_ack = 1;
    after_edge();
    check("R6 id of link2", 32'(id_bus), 32'(BASE + 2));
    at_neg(); cpu_ack = 0;
    after_edge();
    check("R8 all cleared", 32'(pending), 0);

    // R7 request during acknowledge
    pulse_req(4'b1000);
    at_neg(); cpu_ack = 1;
    after_edge();
    check("R6 id of link3", 32'(id_bus), 32'(BASE + 3));
    pulse_req(4'b0001);
    check("R7 late req pending", 32'(pending), 32'b1001);
    check("R7 id unchanged", 32'(id_bus), 32'(BASE + 3));
    check("R7 chain stays blocked", 32'(chain_ack_out), 0);
    at_neg(); cpu_ack = 0;
    after_edge();
    check("R8 only holder cleared", 32'(pending), 32'b0001);
    at_neg(); cpu_ack = 1;
    after_edge();
    check("R5 link0 wins", 32'(id_bus), 32'(BASE));
    check("R9 single holder valid", 32'(id_valid), 1);
    at_neg(); cpu_ack = 0;
    after_edge();
    check("R8 final clear", 32'(pending), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule